// File: doc/BRIEF.md
# Sub-Word Access Register File

This block holds eight 32-bit integer registers and lets a datapath read and write them at full, half and byte widths. Registers 0 to 3 offer four views: the whole word, the low half (bits 15:0), the low byte (bits 7:0) and the upper byte of the low half (bits 15:8). Registers 4 to 7 offer only the word and half views. A byte access to any of those four is illegal.

There is one write port and two read ports. Each write carries a register index, a view selector and an extension mode. In merge mode a narrow write changes only the bits under its view and keeps the rest. In sign-extend or zero-extend mode the narrow value is placed at bit 0 and the whole register is rewritten with the extension. This lets a narrow move that replaces the whole destination finish in a single cycle. The read ports are combinational and return the selected view zero-extended to 32 bits.

Top module: `subword_regfile`

## Requirements
- R1: While `rst_n` is low, every register clears to zero and `wr_err` is low.
- R2: A write with view code 2'b00 (word) stores all 32 bits of `wr_data`. The extension mode has no effect on it.
- R3: A merge write (mode 2'b00 or 2'b11) with view 2'b10 (low byte) replaces bits 7:0 with `wr_data[7:0]` and keeps bits 31:8. For example, 0x98765432 merged with 0x8D gives 0x9876548D.
- R4: A merge write with view 2'b11 (high byte) replaces bits 15:8 with `wr_data[7:0]` and keeps all other bits.
- R5: A merge write with view 2'b01 (half) replaces bits 15:0 with `wr_data[15:0]` and keeps bits 31:16.
- R6: Mode 2'b01 (sign-extend) on a narrow view writes the whole register. A half view takes `wr_data[15:0]` with bit 15 copied upward. Either byte view takes `wr_data[7:0]` with bit 7 copied upward, so 0x8D becomes 0xFFFFFF8D.
- R7: Mode 2'b10 (zero-extend) on a narrow view writes the whole register with zeros above the narrow value. A byte of 0x8D becomes 0x0000008D.
- R8: A write with a byte view (2'b10 or 2'b11) to index 4 to 7 leaves every register unchanged. In that case `wr_err` is high in the cycle after the request edge, and only then. Legal writes and idle cycles leave `wr_err` low.
- R9: A read with view 2'b00 returns the whole register. View 2'b01 returns bits 15:0, view 2'b10 returns bits 7:0 and view 2'b11 returns bits 15:8. Narrow views are zero-extended. A byte view on index 4 to 7 returns zero.
- R10: Reads are combinational. A write takes effect at the clock edge, so a read of the same register in the write cycle returns the old value. Both read ports work independently of each other.
- R11: With `wr_en` low, no register changes, whatever the other write inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 3 | Write register index |
| wr_size | input | 2 | Write view: 00 word, 01 half, 10 low byte, 11 high byte |
| wr_mode | input | 2 | Extension: 00 merge, 01 sign, 10 zero, 11 merge |
| wr_data | input | 32 | Write value, right-aligned |
| wr_err | output | 1 | One-cycle pulse after an illegal byte write |
| rda_idx | input | 3 | Read port A index |
| rda_size | input | 2 | Read port A view |
| rda_data | output | 32 | Read port A value |
| rdb_idx | input | 3 | Read port B index |
| rdb_size | input | 2 | Read port B view |
| rdb_data | output | 32 | Read port B value |

## Verification
A write and a read of the same register often fall in the same cycle. So do an illegal byte write and a read of the register it targets. The random stimulus draws indices from only eight values, so read and write indices often match. Directed steps also place a read on the written register in the same cycle as each narrow write. In every such cycle the read value is compared with the bench model's value from before the edge. The register contents are compared after the edge, and `wr_err` is checked one cycle later.

// File: rtl/swrf_pkg.sv
package swrf_pkg;

  typedef enum logic [1:0] {
    VIEW_WORD = 2'b00,
    VIEW_HALF = 2'b01,
    VIEW_LOB  = 2'b10,
    VIEW_HIB  = 2'b11
  } view_e;

  typedef enum logic [1:0] {
    FILL_MERGE = 2'b00,
    FILL_SIGN  = 2'b01,
    FILL_ZERO  = 2'b10,
    FILL_KEEP  = 2'b11
  } fill_e;

  function automatic logic is_byte_view(input logic [1:0] sz);
    return (sz == VIEW_LOB) || (sz == VIEW_HIB);
  endfunction

endpackage

// File: rtl/swrf_wr_shaper.sv
module swrf_wr_shaper
  import swrf_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] old_i,
  input  logic [XLEN-1:0] data_i,
  input  logic [1:0]      size_i,
  input  logic [1:0]      mode_i,
  output logic [XLEN-1:0] new_o
);

  view_e view;
  fill_e fill;

  assign view = view_e'(size_i);
  assign fill = fill_e'(mode_i);

  always_comb begin
    new_o = old_i;
    unique case (view)
      VIEW_WORD: new_o = data_i;
      VIEW_HALF: begin
        if (fill == FILL_SIGN) begin
          new_o       = {XLEN{data_i[15]}};
          new_o[15:0] = data_i[15:0];
        end else if (fill == FILL_ZERO) begin
          new_o       = '0;
          new_o[15:0] = data_i[15:0];
        end else begin
          new_o[15:0] = data_i[15:0];
        end
      end
      VIEW_LOB, VIEW_HIB: begin
        if (fill == FILL_SIGN) begin
          new_o      = {XLEN{data_i[7]}};
          new_o[7:0] = data_i[7:0];
        end else if (fill == FILL_ZERO) begin
          new_o      = '0;
          new_o[7:0] = data_i[7:0];
        end else if (view == VIEW_LOB) begin
          new_o[7:0] = data_i[7:0];
        end else begin
          new_o[15:8] = data_i[7:0];
        end
      end
      default: new_o = old_i;
    endcase
  end

  always_comb begin
    if (!$isunknown({old_i, size_i, mode_i})) begin
      // R3
      merge_lob_keeps_upper_chk: assert (!(view == VIEW_LOB &&
          (fill == FILL_MERGE || fill == FILL_KEEP)) ||
          new_o[XLEN-1:8] == old_i[XLEN-1:8]);
    end
  end

endmodule

// File: rtl/swrf_rd_view.sv
module swrf_rd_view
  import swrf_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int IDXW   = 3,
  parameter int NBYTER = 4
) (
  input  logic [XLEN-1:0] word_i,
  input  logic [IDXW-1:0] idx_i,
  input  logic [1:0]      size_i,
  output logic [XLEN-1:0] data_o
);

  logic byte_ok;
  assign byte_ok = ({1'b0, idx_i} < (IDXW+1)'(NBYTER));

  always_comb begin
    data_o = '0;
    unique case (view_e'(size_i))
      VIEW_WORD: data_o = word_i;
      VIEW_HALF: data_o[15:0] = word_i[15:0];
      VIEW_LOB:  if (byte_ok) data_o[7:0] = word_i[7:0];
      VIEW_HIB:  if (byte_ok) data_o[7:0] = word_i[15:8];
      default:   data_o = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown({idx_i, size_i})) begin
      // R9
      illegal_byte_read_zero_chk: assert (byte_ok || !is_byte_view(size_i) ||
                                          data_o == '0);
    end
  end

endmodule

// File: rtl/subword_regfile.sv
module subword_regfile
  import swrf_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int NREG   = 8,
  parameter int NBYTER = 4,
  localparam int IDXW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [1:0]      wr_size,
  input  logic [1:0]      wr_mode,
  input  logic [XLEN-1:0] wr_data,
  output logic            wr_err,
  input  logic [IDXW-1:0] rda_idx,
  input  logic [1:0]      rda_size,
  output logic [XLEN-1:0] rda_data,
  input  logic [IDXW-1:0] rdb_idx,
  input  logic [1:0]      rdb_size,
  output logic [XLEN-1:0] rdb_data
);

  logic [NREG-1:0][XLEN-1:0] regs_q;
  logic [NREG-1:0]           reg_we;
  logic [XLEN-1:0]           shaped;
  logic                      wr_legal;
  logic                      err_d, err_q;

  assign wr_legal = !is_byte_view(wr_size) ||
                    ({1'b0, wr_idx} < (IDXW+1)'(NBYTER));

  swrf_wr_shaper #(.XLEN(XLEN)) shaper_i (
    .old_i  (regs_q[wr_idx]),
    .data_i (wr_data),
    .size_i (wr_size),
    .mode_i (wr_mode),
    .new_o  (shaped)
  );

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [XLEN-1:0] reg_d;
    always_comb begin
      reg_we[r] = wr_en && wr_legal && (wr_idx == IDXW'(r));
      reg_d     = shaped;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[r] <= '0;
      end else if (reg_we[r]) begin
        regs_q[r] <= reg_d;
      end
    end
  end

  assign err_d = wr_en && !wr_legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign wr_err = err_q;

  swrf_rd_view #(.XLEN(XLEN), .IDXW(IDXW), .NBYTER(NBYTER)) rda_view_i (
    .word_i (regs_q[rda_idx]),
    .idx_i  (rda_idx),
    .size_i (rda_size),
    .data_o (rda_data)
  );

  swrf_rd_view #(.XLEN(XLEN), .IDXW(IDXW), .NBYTER(NBYTER)) rdb_view_i (
    .word_i (regs_q[rdb_idx]),
    .idx_i  (rdb_idx),
    .size_i (rdb_size),
    .data_o (rdb_data)
  );

  // R2
  full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == 2'b00) |=> (regs_q[$past(wr_idx)] == $past(wr_data)));

  // R8
  illegal_write_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_byte_view(wr_size) && ({1'b0, wr_idx} >= (IDXW+1)'(NBYTER)))
      |=> $stable(regs_q));

  // R8
  err_pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_err) |-> $past(wr_en && is_byte_view(wr_size)));

  // R11
  idle_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_q));

endmodule

// File: tb/subword_regfile_tb_top.sv
`timescale 1ns/1ps
module subword_regfile_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [1:0]  wr_size, wr_mode;
  logic [31:0] wr_data;
  logic        wr_err;
  logic [2:0]  rda_idx, rdb_idx;
  logic [1:0]  rda_size, rdb_size;
  logic [31:0] rda_data, rdb_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] mdl [8];
  logic        exp_err;

  always #2 clk = ~clk;

  subword_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_size(wr_size), .wr_mode(wr_mode), .wr_data(wr_data), .wr_err(wr_err),
    .rda_idx(rda_idx), .rda_size(rda_size), .rda_data(rda_data),
    .rdb_idx(rdb_idx), .rdb_size(rdb_size), .rdb_data(rdb_data)
  );

  function automatic logic [31:0] mdl_write(input logic [31:0] old, input logic [31:0] d,
                                            input logic [1:0] sz, input logic [1:0] md);
    case (sz)
      2'd0: return d;
      2'd1: return (md == 2'd1) ? {{16{d[15]}}, d[15:0]} :
                   (md == 2'd2) ? {16'h0, d[15:0]} : {old[31:16], d[15:0]};
      2'd2: return (md == 2'd1) ? {{24{d[7]}}, d[7:0]} :
                   (md == 2'd2) ? {24'h0, d[7:0]} : {old[31:8], d[7:0]};
      default: return (md == 2'd1) ? {{24{d[7]}}, d[7:0]} :
                      (md == 2'd2) ? {24'h0, d[7:0]} : {old[31:16], d[7:0], old[7:0]};
    endcase
  endfunction

  function automatic logic [31:0] mdl_read(input logic [31:0] v, input logic [2:0] idx,
                                           input logic [1:0] sz);
    case (sz)
      2'd0: return v;
      2'd1: return {16'h0, v[15:0]};
      2'd2: return (idx < 3'd4) ? {24'h0, v[7:0]} : 32'h0;
      default: return (idx < 3'd4) ? {24'h0, v[15:8]} : 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One cycle: drive, check reads (pre-edge state) and wr_err, then update model at edge.
  task automatic step(input logic we, input logic [2:0] wi, input logic [1:0] ws,
                      input logic [1:0] wm, input logic [31:0] wd,
                      input logic [2:0] ai, input logic [1:0] as_,
                      input logic [2:0] bi, input logic [1:0] bs, input string tag);
    @(negedge clk);
    wr_en = we; wr_idx = wi; wr_size = ws; wr_mode = wm; wr_data = wd;
    rda_idx = ai; rda_size = as_; rdb_idx = bi; rdb_size = bs;
    #0.5;
    check({tag, " rdA"}, rda_data, mdl_read(mdl[ai], ai, as_));
    check({tag, " rdB"}, rdb_data, mdl_read(mdl[bi], bi, bs));
    check("R8 wr_err", {31'h0, wr_err}, {31'h0, exp_err});
    @(posedge clk);
    exp_err = we && ws[1] && wi >= 3'd4;
    if (we && !(ws[1] && wi >= 3'd4)) mdl[wi] = mdl_write(mdl[wi], wd, ws, wm);
  endtask

  // Readback of a register's full word on port A after a write.
  task automatic peek(input logic [2:0] i, input string tag);
    step(1'b0, 3'd0, 2'd0, 2'd0, 32'hDEAD_BEEF, i, 2'd0, i, 2'd0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) mdl[i] = 32'h0;
    exp_err = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_size = '0; wr_mode = '0;
    wr_data = 32'hFFFF_FFFF; rda_idx = '0; rda_size = '0; rdb_idx = '0; rdb_size = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state on all registers
    for (int i = 0; i < 8; i++) peek(3'(i), "R1 reset");

    // R2: full write, mode ignored
    step(1, 3'd0, 2'd0, 2'd1, 32'h9876_5432, 3'd0, 2'd0, 3'd0, 2'd0, "R10 same-cycle");
    peek(3'd0, "R2 word write");
    // R3: merge low byte
    step(1, 3'd0, 2'd2, 2'd0, 32'h0000_008D, 3'd0, 2'd0, 3'd0, 2'd2, "R10 same-cycle");
    peek(3'd0, "R3 merge low byte");
    // R4: merge high byte
    step(1, 3'd0, 2'd3, 2'd3, 32'h0000_00C1, 3'd0, 2'd3, 3'd1, 2'd0, "R10 same-cycle");
    peek(3'd0, "R4 merge high byte");
    // R5: merge half
    step(1, 3'd0, 2'd1, 2'd0, 32'h1111_ABCD, 3'd0, 2'd1, 3'd0, 2'd0, "R10 same-cycle");
    peek(3'd0, "R5 merge half");
    // R6: sign extension byte and half
    step(1, 3'd1, 2'd0, 2'd0, 32'h9876_5432, 3'd1, 2'd0, 3'd1, 2'd0, "R10 same-cycle");
    step(1, 3'd1, 2'd2, 2'd1, 32'h0000_008D, 3'd1, 2'd0, 3'd1, 2'd2, "R10 same-cycle");
    peek(3'd1, "R6 sign byte");
    step(1, 3'd6, 2'd1, 2'd1, 32'h0000_8001, 3'd6, 2'd0, 3'd6, 2'd1, "R10 same-cycle");
    peek(3'd6, "R6 sign half");
    step(1, 3'd2, 2'd3, 2'd1, 32'h0000_007F, 3'd2, 2'd3, 3'd2, 2'd0, "R10 same-cycle");
    peek(3'd2, "R6 sign high-byte view");
    // R7: zero extension
    step(1, 3'd3, 2'd0, 2'd0, 32'h9876_5432, 3'd3, 2'd0, 3'd3, 2'd0, "R10 same-cycle");
    step(1, 3'd3, 2'd2, 2'd2, 32'hFFFF_FF8D, 3'd3, 2'd0, 3'd3, 2'd0, "R10 same-cycle");
    peek(3'd3, "R7 zero byte");
    // R8: illegal byte writes on 4..7
    step(1, 3'd5, 2'd0, 2'd0, 32'h5555_5555, 3'd5, 2'd0, 3'd5, 2'd0, "R10 same-cycle");
    step(1, 3'd5, 2'd2, 2'd0, 32'h0000_00AA, 3'd5, 2'd2, 3'd5, 2'd1, "R9 illegal byte read");
    peek(3'd5, "R8 illegal write suppressed");
    step(1, 3'd7, 2'd3, 2'd1, 32'h0000_00AA, 3'd7, 2'd3, 3'd5, 2'd3, "R9 illegal byte read");
    step(1, 3'd6, 2'd2, 2'd2, 32'h0000_00AA, 3'd6, 2'd0, 3'd7, 2'd0, "R8 back-to-back");
    peek(3'd6, "R8 illegal write suppressed");
    peek(3'd7, "R8 illegal write suppressed");
    // R11: write inputs active but wr_en low
    step(0, 3'd0, 2'd0, 2'd0, 32'h0BAD_0BAD, 3'd0, 2'd0, 3'd0, 2'd0, "R11 idle");
    peek(3'd0, "R11 no change with wr_en low");

    // Random mix, R9/R10 reads checked against model every cycle
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] d;
      d = $urandom();
      if (n % 5 == 0) d = {d[31:16], 8'h80 | d[7:0], d[7:0]} ;
      step(($urandom() % 4) != 0, 3'($urandom()), 2'($urandom()), 2'($urandom()), d,
           3'($urandom()), 2'($urandom()), 3'($urandom()), 2'($urandom()),
           "R9 random read");
    end
    for (int i = 0; i < 8; i++) peek(3'(i), "R10 final contents");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule